// File: doc/BRIEF.md
# Serial Overhead Access Channel Formatter

This block feeds a serial overhead access port on the receive side of a SONET path. Upstream logic extracts the twelve data communication channel bytes (DCC1 to DCC12) from each incoming frame and writes them into the block through a simple indexed load port. At each frame boundary the block takes a snapshot of the twelve bytes. During the following frame it shifts the snapshot out on a serial data pin next to a gated serial clock. Each frame starts with a parity byte.

Two selection inputs pick how much of the channel goes out. With both low, all twelve bytes are sent. One input selects DCC4 to DCC12 only, and the other selects DCC1 to DCC3 only. If both are high, the DCC4 to DCC12 selection wins. Each selection has its own number of bit slots per 125 us frame, and so its own effective serial clock rate: 832 kHz, 640 kHz or 260 kHz. A phase accumulator places these slots evenly across the frame. A polarity input chooses even or odd parity for the leading byte. Selection and polarity are sampled only at a frame boundary.

Top module: `oh_serial_fmt`

## Requirements
- R1: After reset the serial clock and data outputs are low and stay low until the first frame pulse. The sampled controls reset to all-bytes selection with odd parity, and the byte store resets to zero, so a frame sent with nothing loaded is 0xFF followed by 96 zero bits.
- R2: With both selection inputs low, a frame carries 104 bits: the parity byte, then DCC1 through DCC12 (load index 0 through 11) in ascending order.
- R3: With only the high-group select set, a frame carries 80 bits: the parity byte, then DCC4 through DCC12 (load index 3 through 11).
- R4: With only the low-group select set, a frame carries 32 bits: the parity byte, then DCC1 through DCC3. One extra half-period pads the 65-half-period frame, and during it the clock stays low.
- R5: When both selection inputs are high at a frame pulse, the frame uses the high-group format of R3.
- R6: The parity byte is the bitwise XOR of the data bytes sent in that frame. It is inverted when the polarity input is 0 (odd parity) and sent unchanged when it is 1 (even parity).
- R7: Each byte is sent MSB first. Data changes only while the serial clock is low or falling, and stays stable while the clock is high, so a receiver samples on the rising edge.
- R8: Selection, polarity and the byte snapshot are taken only at a frame pulse, and changes on those inputs mid-frame do not affect the current frame. A load in the same cycle as a frame pulse goes into the store after the snapshot, so it first appears in the following frame.
- R9: A load whose index is 12 or higher is ignored and leaves every stored byte unchanged.
- R10: All bit slots of a frame finish within FRAME_CLKS system clock cycles of the frame pulse. After that the serial clock holds low until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | One-cycle pulse at each 125 us frame boundary |
| ld_valid_i | input | 1 | Load strobe for one channel byte |
| ld_idx_i | input | 4 | Byte index, 0 = DCC1 ... 11 = DCC12 |
| ld_byte_i | input | 8 | Channel byte value |
| acc_hi_sel_i | input | 1 | Select DCC4 to DCC12 only (has priority) |
| acc_lo_sel_i | input | 1 | Select DCC1 to DCC3 only |
| par_even_i | input | 1 | 1 = even parity, 0 = odd parity |
| soac_clk_o | output | 1 | Gated serial clock |
| soac_data_o | output | 1 | Serial data, changes with the clock's falling edge |

## Verification
Two functions can fall in the same cycle: the frame-boundary snapshot and a byte load. The bench raises a load for DCC1 in the very cycle of a frame pulse. The frame that this pulse starts must still carry the old DCC1 and the old parity, and the frame after it must carry the new value. The same frame also changes the selection inputs partway through, and its bit count and content must stay those of the selection sampled at the pulse.

// File: rtl/oh_serial_pkg.sv
package oh_serial_pkg;

    localparam int BYTE_W   = 8;
    localparam int ALL_CNT  = 12;
    localparam int LOW_CNT  = 3;
    localparam int HIGH_CNT = 9;
    localparam int HIGH_OFS = 3;
    localparam int HALF_MAX = 2 * BYTE_W * (1 + ALL_CNT);
    localparam int HC_W     = $clog2(HALF_MAX + 1);
    localparam int IDX_W    = $clog2(ALL_CNT);
    localparam int POS_W    = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        ACC_ALL  = 2'd0,
        ACC_LOW  = 2'd1,
        ACC_HIGH = 2'd2
    } acc_mode_e;

    // The high group wins when both selects are raised.
    function automatic acc_mode_e decode_mode(logic hi_sel, logic lo_sel);
        if (hi_sel)      return ACC_HIGH;
        else if (lo_sel) return ACC_LOW;
        else             return ACC_ALL;
    endfunction

    function automatic int data_count(acc_mode_e m);
        case (m)
            ACC_HIGH: return HIGH_CNT;
            ACC_LOW:  return LOW_CNT;
            default:  return ALL_CNT;
        endcase
    endfunction

    function automatic int first_index(acc_mode_e m);
        return (m == ACC_HIGH) ? HIGH_OFS : 0;
    endfunction

    // Half-periods that carry bits: parity byte plus data bytes.
    function automatic logic [HC_W-1:0] data_halves(acc_mode_e m);
        return HC_W'(2 * BYTE_W * (1 + data_count(m)));
    endfunction

    // Half-periods per frame. The low group runs at 32.5 bit slots per
    // frame, so one trailing half-period with the clock held low pads it.
    function automatic logic [HC_W-1:0] half_total(acc_mode_e m);
        return data_halves(m) + ((m == ACC_LOW) ? HC_W'(1) : HC_W'(0));
    endfunction

endpackage

// File: rtl/oh_serial_rate.sv
module oh_serial_rate
    import oh_serial_pkg::*;
#(
    parameter int FRAME_CLKS = 25000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start_i,
    input  logic [HC_W-1:0] halves_i,
    output logic [HC_W-1:0] hcnt_o,
    output logic            run_o
);

    localparam int ACC_W = $clog2(FRAME_CLKS + HALF_MAX + 1);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [HC_W-1:0]  hcnt;
        logic             run;
    } rate_t;

    rate_t q, d;
    logic [ACC_W-1:0] sum;

    always_comb begin
        d   = q;
        sum = q.acc + ACC_W'(halves_i);
        if (frame_start_i) begin
            // The pulse cycle is the first of the frame's FRAME_CLKS cycles.
            d.acc  = ACC_W'(halves_i);
            d.hcnt = '0;
            d.run  = 1'b1;
        end else if (q.run && (q.hcnt < halves_i)) begin
            d.acc = sum;
            if (sum >= ACC_W'(FRAME_CLKS)) begin
                d.acc  = sum - ACC_W'(FRAME_CLKS);
                d.hcnt = q.hcnt + HC_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hcnt_o = q.hcnt;
    assign run_o  = q.run;

endmodule

// File: rtl/oh_serial_store.sv
module oh_serial_store
    import oh_serial_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_start_i,
    input  logic                    hi_sel_i,
    input  logic                    lo_sel_i,
    input  logic                    par_even_i,
    input  logic                    ld_valid_i,
    input  logic [IDX_W-1:0]        ld_idx_i,
    input  logic [BYTE_W-1:0]       ld_byte_i,
    output acc_mode_e               mode_o,
    output logic [ALL_CNT*BYTE_W-1:0] active_o,
    output logic [BYTE_W-1:0]       parity_o
);

    typedef struct packed {
        byte_t [ALL_CNT-1:0] stage;
        byte_t [ALL_CNT-1:0] active;
        byte_t               parity;
        acc_mode_e           mode;
    } store_t;

    store_t    q, d;
    acc_mode_e new_mode;
    byte_t     par;
    int        lo_b, hi_b;

    always_comb begin
        d        = q;
        new_mode = decode_mode(hi_sel_i, lo_sel_i);
        lo_b     = first_index(new_mode);
        hi_b     = lo_b + data_count(new_mode);
        par      = '0;
        for (int k = 0; k < ALL_CNT; k++) begin
            if (k >= lo_b && k < hi_b) par = par ^ q.stage[k];
        end
        if (frame_start_i) begin
            d.active = q.stage;
            d.mode   = new_mode;
            d.parity = par_even_i ? par : ~par;
        end
        // Written after the snapshot: a same-cycle load lands next frame.
        if (ld_valid_i && (int'(ld_idx_i) < ALL_CNT)) begin
            d.stage[ld_idx_i] = ld_byte_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.parity <= '1;
            q.mode   <= ACC_ALL;
        end else begin
            q <= d;
        end
    end

    assign mode_o   = q.mode;
    assign active_o = q.active;
    assign parity_o = q.parity;

endmodule

// File: rtl/oh_serial_shift.sv
module oh_serial_shift
    import oh_serial_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run_i,
    input  logic [HC_W-1:0]           hcnt_i,
    input  acc_mode_e                 mode_i,
    input  logic [ALL_CNT*BYTE_W-1:0] active_i,
    input  logic [BYTE_W-1:0]         parity_i,
    output logic                      ser_clk_o,
    output logic                      ser_data_o
);

    typedef struct packed {
        logic sclk;
        logic sdat;
    } out_t;

    out_t             q, d;
    int               bit_n, byte_n;
    logic [IDX_W-1:0] src;
    logic [POS_W-1:0] pos;
    byte_t            cur;

    always_comb begin
        d      = '0;
        bit_n  = int'(hcnt_i) >> 1;
        byte_n = bit_n / BYTE_W;
        pos    = POS_W'(BYTE_W - 1 - (bit_n % BYTE_W));
        src    = IDX_W'(first_index(mode_i) + byte_n - 1);
        cur    = parity_i;
        if (byte_n != 0) cur = active_i[int'(src)*BYTE_W +: BYTE_W];
        if (run_i && (hcnt_i < data_halves(mode_i))) begin
            // Even half: clock low, new bit. Odd half: clock high.
            d.sclk = hcnt_i[0];
            d.sdat = cur[pos];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ser_clk_o  = q.sclk;
    assign ser_data_o = q.sdat;

endmodule

// File: rtl/oh_serial_fmt.sv
module oh_serial_fmt
    import oh_serial_pkg::*;
#(
    parameter int FRAME_CLKS = 25000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start_i,
    input  logic             ld_valid_i,
    input  logic [IDX_W-1:0] ld_idx_i,
    input  logic [BYTE_W-1:0] ld_byte_i,
    input  logic             acc_hi_sel_i,
    input  logic             acc_lo_sel_i,
    input  logic             par_even_i,
    output logic             soac_clk_o,
    output logic             soac_data_o
);

    acc_mode_e                 mode_q;
    logic [ALL_CNT*BYTE_W-1:0] active_q;
    logic [BYTE_W-1:0]         parity_q;
    logic [HC_W-1:0]           hcnt_q;
    logic                      run_q;
    logic [HC_W-1:0]           halves_now;

    // Slot total of the selection that governs this cycle.
    always_comb begin
        if (frame_start_i) halves_now = half_total(decode_mode(acc_hi_sel_i, acc_lo_sel_i));
        else               halves_now = half_total(mode_q);
    end

    oh_serial_store u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start_i(frame_start_i),
        .hi_sel_i     (acc_hi_sel_i),
        .lo_sel_i     (acc_lo_sel_i),
        .par_even_i   (par_even_i),
        .ld_valid_i   (ld_valid_i),
        .ld_idx_i     (ld_idx_i),
        .ld_byte_i    (ld_byte_i),
        .mode_o       (mode_q),
        .active_o     (active_q),
        .parity_o     (parity_q)
    );

    oh_serial_rate #(.FRAME_CLKS(FRAME_CLKS)) u_rate (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start_i(frame_start_i),
        .halves_i     (halves_now),
        .hcnt_o       (hcnt_q),
        .run_o        (run_q)
    );

    oh_serial_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_q),
        .hcnt_i    (hcnt_q),
        .mode_i    (mode_q),
        .active_i  (active_q),
        .parity_i  (parity_q),
        .ser_clk_o (soac_clk_o),
        .ser_data_o(soac_data_o)
    );

endmodule

// File: rtl/oh_serial_fmt_chk.sv
module oh_serial_fmt_chk
    import oh_serial_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            frame_start,
    input logic            hi_sel,
    input logic            ser_clk,
    input logic            ser_data,
    input logic            run,
    input logic [HC_W-1:0] hcnt,
    input acc_mode_e       mode
);

    // R7
    clk_high_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    // R10
    slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (hcnt <= half_total(mode)));

    // R1
    idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !ser_clk);

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(mode));

    // R5
    hi_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && hi_sel) |=> (mode == ACC_HIGH));

    // R4
    pad_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == ACC_LOW && hcnt >= data_halves(ACC_LOW)) |=> !ser_clk);

endmodule

bind oh_serial_fmt oh_serial_fmt_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start_i),
    .hi_sel     (acc_hi_sel_i),
    .ser_clk    (soac_clk_o),
    .ser_data   (soac_data_o),
    .run        (run_q),
    .hcnt       (hcnt_q),
    .mode       (mode_q)
);

// File: tb/oh_serial_fmt_tb.sv
module oh_serial_fmt_tb;

    localparam int FCLK = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       ld_valid = 1'b0;
    logic [3:0] ld_idx = '0;
    logic [7:0] ld_byte = '0;
    logic       hi_sel = 1'b0;
    logic       lo_sel = 1'b0;
    logic       par_even = 1'b0;
    logic       soac_clk;
    logic       soac_data;

    int checks = 0;
    int fails = 0;
    int r7_err = 0;
    int total_rises = 0;
    bit done = 1'b0;

    logic [7:0] exp_stage [12];
    logic [7:0] exp_act [12];
    logic       cap [128];
    logic       expb [128];
    int         ncap = 0;
    int         nexp = 0;
    logic       prev_clk = 1'b0;
    logic       prev_data = 1'b0;

    always #2.5 clk = ~clk;

    oh_serial_fmt #(.FRAME_CLKS(FCLK)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start_i(frame_start),
        .ld_valid_i   (ld_valid),
        .ld_idx_i     (ld_idx),
        .ld_byte_i    (ld_byte),
        .acc_hi_sel_i (hi_sel),
        .acc_lo_sel_i (lo_sel),
        .par_even_i   (par_even),
        .soac_clk_o   (soac_clk),
        .soac_data_o  (soac_data)
    );

    // Capture data on each rising serial clock; watch data while high (R7).
    always @(negedge clk) begin
        if (soac_clk && !prev_clk) begin
            if (ncap < 128) cap[ncap] = soac_data;
            ncap++;
            total_rises++;
        end
        if (soac_clk && prev_clk && (soac_data != prev_data)) r7_err++;
        prev_clk  = soac_clk;
        prev_data = soac_data;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic [7:0] val);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_idx   = 4'(idx);
        ld_byte  = val;
        if (idx < 12) exp_stage[idx] = val;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    // Builds the expected bit stream from the bench's own model.
    task automatic build_expect(input logic h, input logic l, input logic ev);
        int cnt, ofs;
        logic [7:0] par, b;
        cnt = h ? 9 : (l ? 3 : 12);
        ofs = h ? 3 : 0;
        par = 8'h00;
        for (int k = 0; k < cnt; k++) par = par ^ exp_act[ofs + k];
        if (!ev) par = ~par;
        nexp = 8 * (cnt + 1);
        for (int i = 0; i < nexp; i++) begin
            b = (i < 8) ? par : exp_act[ofs + i / 8 - 1];
            expb[i] = b[7 - (i % 8)];
        end
    endtask

    task automatic do_frame(input string req, input logic h, input logic l, input logic ev,
                            input logic ld_en, input int lidx, input logic [7:0] lval,
                            input logic chg_en, input logic ch, input logic cl);
        int bad;
        @(negedge clk);
        hi_sel = h; lo_sel = l; par_even = ev;
        frame_start = 1'b1;
        for (int k = 0; k < 12; k++) exp_act[k] = exp_stage[k];
        build_expect(h, l, ev);
        if (ld_en) begin
            ld_valid = 1'b1; ld_idx = 4'(lidx); ld_byte = lval;
            if (lidx < 12) exp_stage[lidx] = lval;
        end
        ncap = 0;
        @(negedge clk);
        frame_start = 1'b0;
        ld_valid = 1'b0;
        repeat (50) @(negedge clk);
        if (chg_en) begin
            hi_sel = ch; lo_sel = cl; par_even = ~ev;
        end
        repeat (FCLK) @(negedge clk);
        chk(req, "bit count", ncap, nexp);
        bad = -1;
        for (int i = 0; i < nexp && i < 128; i++) if (bad < 0 && cap[i] !== expb[i]) bad = i;
        chk(req, "first mismatching bit index (MSB first)", bad, -1);
        chk({req, " R10"}, "clock idle after frame", int'(soac_clk), 0);
    endtask

    task automatic t_reset;
        repeat (5) @(negedge clk);
        chk("R1", "clock in reset", int'(soac_clk), 0);
        chk("R1", "data in reset", int'(soac_data), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R1", "clock before first frame", int'(soac_clk), 0);
        chk("R1", "rises before first frame", ncap, 0);
        // Controls at reset values: all bytes, odd parity, zero store.
        do_frame("R1 R2", 1'b0, 1'b0, 1'b0, 1'b0, 0, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_load_all;
        for (int k = 0; k < 12; k++) load(k, 8'(8'h3C + k * 8'h17));
    endtask

    task automatic t_full;
        do_frame("R2 R6", 1'b0, 1'b0, 1'b0, 1'b0, 0, 8'h00, 1'b0, 1'b0, 1'b0);
        do_frame("R6", 1'b0, 1'b0, 1'b1, 1'b0, 0, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_high;
        do_frame("R3", 1'b1, 1'b0, 1'b0, 1'b0, 0, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_low;
        do_frame("R4", 1'b0, 1'b1, 1'b1, 1'b0, 0, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_both;
        do_frame("R5", 1'b1, 1'b1, 1'b1, 1'b0, 0, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_bad_idx;
        for (int k = 12; k < 16; k++) load(k, 8'hAA);
        do_frame("R9", 1'b0, 1'b0, 1'b0, 1'b0, 0, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_collide;
        // Load at the pulse plus mid-frame control change: old frame intact.
        do_frame("R8", 1'b0, 1'b0, 1'b0, 1'b1, 0, 8'h5A, 1'b1, 1'b0, 1'b1);
        do_frame("R8", 1'b0, 1'b0, 1'b0, 1'b0, 0, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        for (int k = 0; k < 12; k++) exp_stage[k] = 8'h00;
        t_reset();
        t_load_all();
        t_full();
        t_high();
        t_low();
        t_both();
        t_bad_idx();
        t_collide();
        chk("R7", "rises seen overall", int'(total_rises > 0), 1);
        chk("R7", "data changes while clock high", r7_err, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule